// File: doc/BRIEF.md
# Asynchronous Serial Interface Adapter

This block sits on a narrow host bus and turns bytes into asynchronous serial frames and back. A single address bit picks between two register pairs. With the bit clear, a read returns a status byte and a write sets the configuration. With the bit set, a read returns the last received character and a write queues a character for transmission. Frames are fixed at one start bit, eight data bits sent least significant bit first, and one stop bit. Each bit lasts sixteen ticks of an internal oversampling enable. A fixed clock divider produces that enable.

The transmit side has a one-byte holding register in front of a frame shifter. The host can therefore queue the next byte while the current one is still on the line. The receive side waits for a falling edge and checks at mid-bit that the start bit is real. It then samples every data bit at its centre and places the character in a one-byte buffer. If a new frame completes while that buffer is still unread, an overrun flag is latched. A single active-high interrupt request is raised from receive conditions, transmit conditions, or both, depending on two separate enables. A configuration write with both low bits set returns every internal state to its idle value.

An asynchronous active-low reset is released through a two-stage synchroniser inside the block.

Top module: `serial_adapter`

## Requirements
- R1: After hardware reset, `tx_out` and `rts_n` are high, `irq` is low and the status byte reads 0x02.
- R2: With `bus_addr`=0, a read returns status and a write updates configuration. With `bus_addr`=1, a read returns the receive buffer and a write loads the transmit holding register.
- R3: A configuration write whose bits [1:0] equal 2'b11 is a soft reset. On the next cycle `tx_out`=1, `rts_n`=1, `irq`=0 and status reads 0x02: both enables are off, overrun is clear and both buffers are empty. Any frame in progress is abandoned.
- R4: Status bit 1 (transmit empty) drops in the cycle after a transmit-data write. It stays low while a queued byte waits behind a busy shifter. It returns high once the byte has moved into the shifter.
- R5: A transmitted frame is a low start bit, then data bits [0] to [7], then a high stop bit. Each bit is 16*TICK_DIV clock cycles long. The line idles high.
- R6: A falling edge on `rx_in` starts reception. Each bit is sampled at its centre. When the stop bit has been sampled, the character is stored and status bit 0 (receive full) is set.
- R7: If the start bit is no longer low at its centre, reception is abandoned and nothing is stored. The next real frame is received normally.
- R8: A frame that completes while status bit 0 is still set sets status bit 5 (overrun). The new character replaces the old one.
- R9: A read with `bus_addr`=1 clears status bits 0 and 5.
- R10: `irq` = (receive enable AND (status bit 0 OR bit 5)) OR (transmit enable AND status bit 1). Status bit 7 always equals `irq`.
- R11: Configuration bit 7 is the receive interrupt enable. Bits [6:5]=01 set the transmit enable and drive `rts_n` low. Bits [6:5]=10 clear the transmit enable and drive `rts_n` high. Bits [6:5]=00 or 11 clear the transmit enable and drive `rts_n` low.
- R12: When a receive-data read and a frame completion fall in the same cycle, the following holds:
  - the read returns the old character;
  - the new character is stored;
  - status bit 0 stays set;
  - no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | Register pair select |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on `bus_addr` |
| rx_in | input | 1 | Serial receive line, idle high |
| tx_out | output | 1 | Serial transmit line, idle high |
| rts_n | output | 1 | Request-to-send, active low |
| irq | output | 1 | Interrupt request, active high |

## Verification
A host read of the receive buffer and the completion of a new frame can land in the same cycle. This is the one place where a clear and a set compete for the receive-full and overrun flags. The bench first measures the latency from a start edge it drives to the rise of `irq`. It then replays a second frame with the read strobe placed exactly on the completion cycle. The test passes when the read returns the older character, receive-full stays set with overrun clear, and the next read returns the newer character.

// File: rtl/sa_pkg.sv
package sa_pkg;

  localparam int unsigned OVERSAMPLE = 16;

  localparam int unsigned ST_RX_FULL  = 0;
  localparam int unsigned ST_TX_EMPTY = 1;
  localparam int unsigned ST_OVERRUN  = 5;
  localparam int unsigned ST_IRQ      = 7;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2
  } rx_state_e;

endpackage

// File: rtl/sa_tick_gen.sv
module sa_tick_gen #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic tick
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == LAST);

  always_comb begin
    if (clear || tick) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sa_tx_unit.sv
module sa_tx_unit
  import sa_pkg::*;
#(
  parameter int unsigned DATA_BITS = 8,
  parameter int unsigned TICK_DIV  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 soft_rst,
  input  logic                 wr_data,
  input  logic [DATA_BITS-1:0] wdata,
  output logic                 tx_line,
  output logic                 hold_empty
);
  localparam int unsigned FRAME = DATA_BITS + 2;
  localparam int unsigned CW    = $clog2(FRAME);
  localparam int unsigned TW    = $clog2(OVERSAMPLE);
  localparam logic [CW-1:0] LAST_BIT  = CW'(FRAME - 1);
  localparam logic [TW-1:0] LAST_TICK = TW'(OVERSAMPLE - 1);

  logic [DATA_BITS-1:0] hold_q, hold_d;
  logic                 full_q, full_d;
  logic [FRAME-1:0]     sh_q, sh_d;
  logic                 busy_q, busy_d;
  logic [CW-1:0]        bitn_q, bitn_d;
  logic [TW-1:0]        tcnt_q, tcnt_d;
  logic                 load, tick;

  assign load = full_q && !busy_q && !soft_rst;

  sa_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (load || soft_rst),
    .tick  (tick)
  );

  always_comb begin
    hold_d = hold_q;
    full_d = full_q;
    sh_d   = sh_q;
    busy_d = busy_q;
    bitn_d = bitn_q;
    tcnt_d = tcnt_q;
    if (soft_rst) begin
      hold_d = '0;
      full_d = 1'b0;
      sh_d   = '1;
      busy_d = 1'b0;
      bitn_d = '0;
      tcnt_d = '0;
    end else begin
      if (load) begin
        sh_d   = {1'b1, hold_q, 1'b0};
        busy_d = 1'b1;
        bitn_d = '0;
        tcnt_d = '0;
        full_d = 1'b0;
      end else if (busy_q && tick) begin
        if (tcnt_q == LAST_TICK) begin
          tcnt_d = '0;
          sh_d   = {1'b1, sh_q[FRAME-1:1]};
          bitn_d = bitn_q + 1'b1;
          if (bitn_q == LAST_BIT) busy_d = 1'b0;
        end else begin
          tcnt_d = tcnt_q + 1'b1;
        end
      end
      if (wr_data) begin
        hold_d = wdata;
        full_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      full_q <= 1'b0;
      sh_q   <= '1;
      busy_q <= 1'b0;
      bitn_q <= '0;
      tcnt_q <= '0;
    end else begin
      hold_q <= hold_d;
      full_q <= full_d;
      sh_q   <= sh_d;
      busy_q <= busy_d;
      bitn_q <= bitn_d;
      tcnt_q <= tcnt_d;
    end
  end

  assign tx_line    = sh_q[0];
  assign hold_empty = !full_q;

  // R5: an idle shifter keeps the line high
  p_idle_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> tx_line);
  // R5: a load puts the start bit on the line
  p_start_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !tx_line);
  // R4: a load without a fresh write empties the holding register
  p_load_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !wr_data) |=> (busy_q && !full_q));

endmodule

// File: rtl/sa_rx_unit.sv
module sa_rx_unit
  import sa_pkg::*;
#(
  parameter int unsigned DATA_BITS = 8,
  parameter int unsigned TICK_DIV  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 soft_rst,
  input  logic                 rx_line,
  output logic                 done,
  output logic [DATA_BITS-1:0] char_out
);
  localparam int unsigned SAMPLES = DATA_BITS + 1;
  localparam int unsigned NW      = $clog2(SAMPLES + 1);
  localparam int unsigned TW      = $clog2(OVERSAMPLE);
  localparam logic [NW-1:0] LAST_N    = NW'(SAMPLES - 1);
  localparam logic [TW-1:0] LAST_TICK = TW'(OVERSAMPLE - 1);
  localparam logic [TW-1:0] HALF_TICK = TW'(OVERSAMPLE / 2 - 1);

  logic                 s1_q, s2_q, prev_q;
  rx_state_e            state_q, state_d;
  logic [TW-1:0]        tcnt_q, tcnt_d;
  logic [NW-1:0]        nbits_q, nbits_d;
  logic [DATA_BITS-1:0] data_q, data_d;
  logic                 done_q, done_d;
  logic                 tick;

  sa_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clear ((state_q == RX_IDLE) || soft_rst),
    .tick  (tick)
  );

  always_comb begin
    state_d = state_q;
    tcnt_d  = tcnt_q;
    nbits_d = nbits_q;
    data_d  = data_q;
    done_d  = 1'b0;
    if (soft_rst) begin
      state_d = RX_IDLE;
      tcnt_d  = '0;
      nbits_d = '0;
      data_d  = '0;
    end else begin
      case (state_q)
        RX_IDLE: begin
          if (prev_q && !s2_q) begin
            state_d = RX_START;
            tcnt_d  = '0;
          end
        end
        RX_START: begin
          if (tick) begin
            if (tcnt_q == HALF_TICK) begin
              tcnt_d  = '0;
              nbits_d = '0;
              state_d = s2_q ? RX_IDLE : RX_DATA;
            end else begin
              tcnt_d = tcnt_q + 1'b1;
            end
          end
        end
        RX_DATA: begin
          if (tick) begin
            if (tcnt_q == LAST_TICK) begin
              tcnt_d = '0;
              if (nbits_q == LAST_N) begin
                done_d  = 1'b1;
                state_d = RX_IDLE;
              end else begin
                data_d  = {s2_q, data_q[DATA_BITS-1:1]};
                nbits_d = nbits_q + 1'b1;
              end
            end else begin
              tcnt_d = tcnt_q + 1'b1;
            end
          end
        end
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= 1'b1;
      s2_q    <= 1'b1;
      prev_q  <= 1'b1;
      state_q <= RX_IDLE;
      tcnt_q  <= '0;
      nbits_q <= '0;
      data_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      s1_q    <= rx_line;
      s2_q    <= s1_q;
      prev_q  <= s2_q;
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
      nbits_q <= nbits_d;
      data_q  <= data_d;
      done_q  <= done_d;
    end
  end

  assign done     = done_q;
  assign char_out = data_q;

  // R7: a start bit found high at its centre returns to idle without a frame
  p_glitch_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_START && tick && tcnt_q == HALF_TICK && s2_q && !soft_rst)
      |=> (state_q == RX_IDLE && !done_q));
  // R6: frame completion is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/serial_adapter.sv
module serial_adapter
  import sa_pkg::*;
#(
  parameter int unsigned TICK_DIV = 4
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       rx_in,
  output logic       tx_out,
  output logic       rts_n,
  output logic       irq
);
  localparam int unsigned DATA_BITS = 8;

  logic rs1_q, rs2_q, rst_n;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_n = rs2_q;

  logic wr_ctrl, wr_data, rd_data, soft_rst;
  assign wr_ctrl  = bus_wr && !bus_addr;
  assign wr_data  = bus_wr &&  bus_addr;
  assign rd_data  = bus_rd &&  bus_addr;
  assign soft_rst = wr_ctrl && (bus_wdata[1:0] == 2'b11);

  logic                 tx_empty, rx_done;
  logic [DATA_BITS-1:0] rx_char;

  sa_tx_unit #(.DATA_BITS(DATA_BITS), .TICK_DIV(TICK_DIV)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .wr_data    (wr_data),
    .wdata      (bus_wdata),
    .tx_line    (tx_out),
    .hold_empty (tx_empty)
  );

  sa_rx_unit #(.DATA_BITS(DATA_BITS), .TICK_DIV(TICK_DIV)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .rx_line  (rx_in),
    .done     (rx_done),
    .char_out (rx_char)
  );

  logic                 rx_ie_q, rx_ie_d;
  logic                 tx_ie_q, tx_ie_d;
  logic                 rts_n_q, rts_n_d;
  logic                 rx_full_q, rx_full_d;
  logic                 ovr_q, ovr_d;
  logic [DATA_BITS-1:0] rx_buf_q, rx_buf_d;

  always_comb begin
    rx_ie_d   = rx_ie_q;
    tx_ie_d   = tx_ie_q;
    rts_n_d   = rts_n_q;
    rx_full_d = rx_full_q;
    ovr_d     = ovr_q;
    rx_buf_d  = rx_buf_q;
    if (soft_rst) begin
      rx_ie_d   = 1'b0;
      tx_ie_d   = 1'b0;
      rts_n_d   = 1'b1;
      rx_full_d = 1'b0;
      ovr_d     = 1'b0;
      rx_buf_d  = '0;
    end else begin
      if (wr_ctrl) begin
        rx_ie_d = bus_wdata[7];
        case (bus_wdata[6:5])
          2'b01:   begin tx_ie_d = 1'b1; rts_n_d = 1'b0; end
          2'b10:   begin tx_ie_d = 1'b0; rts_n_d = 1'b1; end
          default: begin tx_ie_d = 1'b0; rts_n_d = 1'b0; end
        endcase
      end
      if (rd_data) begin
        rx_full_d = 1'b0;
        ovr_d     = 1'b0;
      end
      if (rx_done) begin
        rx_buf_d  = rx_char;
        rx_full_d = 1'b1;
        if (rx_full_q && !rd_data) ovr_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ie_q   <= 1'b0;
      tx_ie_q   <= 1'b0;
      rts_n_q   <= 1'b1;
      rx_full_q <= 1'b0;
      ovr_q     <= 1'b0;
      rx_buf_q  <= '0;
    end else begin
      rx_ie_q   <= rx_ie_d;
      tx_ie_q   <= tx_ie_d;
      rts_n_q   <= rts_n_d;
      rx_full_q <= rx_full_d;
      ovr_q     <= ovr_d;
      rx_buf_q  <= rx_buf_d;
    end
  end

  logic [7:0] status;
  always_comb begin
    status              = '0;
    status[ST_RX_FULL]  = rx_full_q;
    status[ST_TX_EMPTY] = tx_empty;
    status[ST_OVERRUN]  = ovr_q;
    status[ST_IRQ]      = irq;
  end

  assign irq       = (rx_ie_q && (rx_full_q || ovr_q)) || (tx_ie_q && tx_empty);
  assign rts_n     = rts_n_q;
  assign bus_rdata = bus_addr ? rx_buf_q : status;

  // R3: soft reset returns the line, handshake and interrupt to idle
  p_soft_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (tx_out && rts_n && !irq && !rx_full_q && !ovr_q));
  // R8: completion onto an unread buffer latches overrun
  p_overrun_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_full_q && !rd_data && !soft_rst) |=> ovr_q);
  // R9: a data read with no competing completion empties the buffer
  p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !rx_done) |=> (!rx_full_q && !ovr_q));
  // R12: read and completion in one cycle keep the buffer full, no overrun
  p_read_meets_frame_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && rx_done && !soft_rst) |=> (rx_full_q && !ovr_q));
  // R10: with both enables off the request stays low
  p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_ie_q && !tx_ie_q) |-> !irq);
  // R11: configuration 10 in bits 6:5 raises the handshake and drops transmit enable
  p_rts_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !soft_rst && bus_wdata[6:5] == 2'b10) |=> (rts_n && !tx_ie_q));

endmodule

// File: tb/serial_adapter_tb.sv
`timescale 1ns/1ps
module serial_adapter_tb;

  localparam int TICK_DIV = 4;
  localparam int BIT_CLKS = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       arst_n;
  logic       bus_addr, bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata;
  logic       rx_in, tx_out, rts_n, irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  serial_adapter #(.TICK_DIV(TICK_DIV)) u_dut (
    .clk       (clk),
    .arst_n    (arst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .rx_in     (rx_in),
    .tx_out    (tx_out),
    .rts_n     (rts_n),
    .irq       (irq)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0; bus_addr = 1'b0;
    #1;
  endtask

  task automatic get_status(output logic [7:0] v);
    bus_addr = 1'b0;
    #1 v = bus_rdata;
  endtask

  task automatic read_data(output logic [7:0] v);
    bus_addr = 1'b1; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0; bus_addr = 1'b0;
    #1;
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_rx(input logic [7:0] b);
    rx_in = 1'b0; wait_clks(BIT_CLKS);
    for (int i = 0; i < 8; i++) begin
      rx_in = b[i]; wait_clks(BIT_CLKS);
    end
    rx_in = 1'b1; wait_clks(BIT_CLKS);
  endtask

  task automatic capture_tx(input string req, input logic [7:0] exp);
    int guard = 0;
    logic [7:0] got;
    while (tx_out !== 1'b0 && guard < 2000) begin
      @(negedge clk); guard++;
    end
    wait_clks(BIT_CLKS / 2);
    chk(req, "start bit", {7'd0, tx_out}, 8'h00);
    for (int i = 0; i < 8; i++) begin
      wait_clks(BIT_CLKS);
      got[i] = tx_out;
    end
    chk(req, "frame data", got, exp);
    wait_clks(BIT_CLKS);
    chk(req, "stop bit", {7'd0, tx_out}, 8'h01);
  endtask

  task automatic t_reset;
    logic [7:0] s;
    get_status(s);
    chk("R1", "status after reset", s, 8'h02);
    chk("R1", "tx line", {7'd0, tx_out}, 8'h01);
    chk("R1", "rts_n", {7'd0, rts_n}, 8'h01);
    chk("R1", "irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_config;
    logic [7:0] s;
    bus_write(1'b0, 8'h20);
    get_status(s);
    chk("R11", "tx enable status", s, 8'h82);
    chk("R10", "irq from tx empty", {7'd0, irq}, 8'h01);
    chk("R11", "rts_n low for 01", {7'd0, rts_n}, 8'h00);
    chk("R2", "config write leaves line idle", {7'd0, tx_out}, 8'h01);
    bus_write(1'b0, 8'h40);
    get_status(s);
    chk("R11", "status for 10", s, 8'h02);
    chk("R11", "rts_n high for 10", {7'd0, rts_n}, 8'h01);
    bus_write(1'b0, 8'h60);
    chk("R11", "rts_n low for 11", {7'd0, rts_n}, 8'h00);
    chk("R11", "irq off for 11", {7'd0, irq}, 8'h00);
    bus_write(1'b0, 8'h00);
    chk("R11", "rts_n low for 00", {7'd0, rts_n}, 8'h00);
  endtask

  task automatic t_transmit;
    logic [7:0] s;
    bus_write(1'b0, 8'h00);
    bus_write(1'b1, 8'hA5);
    get_status(s);
    chk("R4", "empty drops after write", s, 8'h00);
    wait_clks(3);
    get_status(s);
    chk("R4", "empty back after load", s, 8'h02);
    bus_write(1'b1, 8'h3C);
    capture_tx("R5", 8'hA5);
    get_status(s);
    chk("R4", "queued byte keeps empty low", s, 8'h00);
    capture_tx("R5", 8'h3C);
    wait_clks(BIT_CLKS);
    get_status(s);
    chk("R4", "empty after both frames", s, 8'h02);
  endtask

  task automatic t_soft_reset_tx;
    logic [7:0] s;
    bus_write(1'b0, 8'h20);
    bus_write(1'b1, 8'h77);
    wait_clks(100);
    bus_write(1'b0, 8'h03);
    get_status(s);
    chk("R3", "status after soft reset", s, 8'h02);
    chk("R3", "tx line idle", {7'd0, tx_out}, 8'h01);
    chk("R3", "rts_n high", {7'd0, rts_n}, 8'h01);
    chk("R3", "irq low", {7'd0, irq}, 8'h00);
    wait_clks(12 * BIT_CLKS);
    chk("R3", "frame abandoned", {7'd0, tx_out}, 8'h01);
  endtask

  task automatic t_receive;
    logic [7:0] s, d;
    bus_write(1'b0, 8'h00);
    send_rx(8'h5A);
    get_status(s);
    chk("R6", "receive full", s, 8'h03);
    read_data(d);
    chk("R2/R6", "received byte", d, 8'h5A);
    get_status(s);
    chk("R9", "read empties buffer", s, 8'h02);
  endtask

  task automatic t_glitch;
    logic [7:0] s, d;
    rx_in = 1'b0; wait_clks(5);
    rx_in = 1'b1; wait_clks(12 * BIT_CLKS);
    get_status(s);
    chk("R7", "glitch stores nothing", s, 8'h02);
    send_rx(8'hC3);
    read_data(d);
    chk("R7", "frame after glitch", d, 8'hC3);
  endtask

  task automatic t_overrun;
    logic [7:0] s, d;
    bus_write(1'b0, 8'h80);
    send_rx(8'h11);
    get_status(s);
    chk("R10", "rx irq status", s, 8'h83);
    send_rx(8'h22);
    get_status(s);
    chk("R8", "overrun latched", s, 8'hA3);
    read_data(d);
    chk("R8", "new byte replaced old", d, 8'h22);
    get_status(s);
    chk("R9", "read clears overrun", s, 8'h02);
    chk("R10", "irq drops", {7'd0, irq}, 8'h00);
    send_rx(8'h33);
    send_rx(8'h44);
    bus_write(1'b0, 8'h03);
    get_status(s);
    chk("R3", "soft reset clears overrun", s, 8'h02);
  endtask

  task automatic t_coincide;
    logic [7:0] s, d, during;
    int k = 0;
    bus_write(1'b0, 8'h80);
    fork
      send_rx(8'h44);
      begin
        do begin
          @(posedge clk); @(negedge clk); k++;
        end while (irq !== 1'b1 && k < 2000);
      end
    join
    fork
      send_rx(8'h99);
      begin
        repeat (k - 1) begin @(posedge clk); @(negedge clk); end
        bus_addr = 1'b1; bus_rd = 1'b1;
        #1 during = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0; bus_addr = 1'b0;
      end
    join
    chk("R12", "coincident read returns old", during, 8'h44);
    get_status(s);
    chk("R12", "full kept, no overrun", s, 8'h83);
    read_data(d);
    chk("R12", "new byte stored", d, 8'h99);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    arst_n = 1'b0; bus_addr = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_wdata = '0; rx_in = 1'b1;
    wait_clks(3);
    arst_n = 1'b1;
    wait_clks(4);
    #1;
    t_reset();
    t_config();
    t_transmit();
    t_soft_reset_tx();
    t_receive();
    t_glitch();
    t_overrun();
    t_coincide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule